// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. It takes the accumulator value and a second operand, together with a 4-bit operation code, and produces the new accumulator value combinationally in the same cycle. For the two chained operations, add-with-carry and subtract-with-borrow, the carry input comes from the stored carry flag.

Every operation also yields five condition flags at once: zero, carry, sign, parity and half-carry. These are captured in a byte-wide flag register on the rising clock edge, but only while the flag write-enable is high. Software reads the register back as one byte, with the unused bit positions held at zero.

Top module: `acc_alu`

## Requirements
- R1: Addition family, with op codes ADD=0, ADC=1 and INC=4. `res_out` is the low 8 bits of acc+opnd, of acc+opnd+CY (CY being the stored carry flag) and of acc+1 respectively. The new CY is 1 when the true sum exceeds 255.
- R2: Subtraction family, with op codes SUB=2, SBB=3, DEC=5 and NEG=6. `res_out` is the low 8 bits of acc-opnd, of acc-opnd-CY, of acc-1 and of 0-acc. The new CY is 1 when a borrow occurs, which means the true difference is negative. DEC and NEG ignore `opnd`.
- R3: The zero flag becomes 1 exactly when the 8-bit result is 0. This holds for every operation.
- R4: The sign flag copies result bit 7. The parity flag is 1 when the result has an even number of 1 bits. Both hold for every operation.
- R5: The half-carry flag is the carry out of bit 3 for the addition family and the borrow out of bit 3 for the subtraction family. It is 0 for every other operation.
- R6: Logic family, with op codes AND=7, OR=8, XOR=9, COM=10 (bitwise complement of acc) and CLR=11 (result 0). These operations clear both CY and the half-carry flag. COM and CLR ignore `opnd`.
- R7: Shift family, with op codes SHL=12, SHR=13, ROL=14 and ROR=15. SHL and SHR are logical and fill with 0. ROL and ROR move the end bit around to the other end. In all four, the bit shifted out of the byte goes into CY. The shift operations ignore `opnd`.
- R8: Flag byte layout is S at bit 7, Z at bit 6, half-carry at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 always read 0.
- R9: `flags_q` changes only at a rising edge with `flag_we` high. `res_out` follows the inputs within the same cycle.
- R10: While `rst_n` is low, `flags_q` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_in | input | 8 | Accumulator value |
| opnd | input | 8 | Second operand |
| op | input | 4 | Operation code |
| flag_we | input | 1 | Capture flags at next edge |
| res_out | output | 8 | New accumulator value (combinational) |
| flags_q | output | 8 | Flag register |

## Verification
The only state is the flag register. A wrong bit in it shows on `flags_q` at the edge where it is written. A wrong CY bit also shows one operation later, in the result of an ADC or SBB. The bench reads `res_out` before each edge and `flags_q` just after it, so either kind of fault is seen within two cycles. Long chains of ADC and SBB carry any stale carry forward into the checked results.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBB = 4'd3,
    OP_INC = 4'd4,  OP_DEC = 4'd5,  OP_NEG = 4'd6,  OP_AND = 4'd7,
    OP_OR  = 4'd8,  OP_XOR = 4'd9,  OP_COM = 4'd10, OP_CLR = 4'd11,
    OP_SHL = 4'd12, OP_SHR = 4'd13, OP_ROL = 4'd14, OP_ROR = 4'd15
  } alu_op_e;

  localparam int FLG_S  = 7;
  localparam int FLG_Z  = 6;
  localparam int FLG_AC = 4;
  localparam int FLG_P  = 2;
  localparam int FLG_CY = 0;
  localparam logic [7:0] FLG_SPARE_MASK = 8'b0010_1010;

  function automatic logic uses_adder(alu_op_e o);
    return (o <= OP_NEG);
  endfunction

  function automatic logic is_logic_op(alu_op_e o);
    return (o >= OP_AND) && (o <= OP_CLR);
  endfunction
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         hc
);
  localparam int H = W / 2;

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   full;
  logic [H:0]   half;

  // Subtraction as a + ~b + ~borrow; carry-out inverted gives borrow.
  assign b_eff = b ^ {W{sub}};
  assign c_eff = cin ^ sub;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
  assign half  = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c_eff};
  assign sum   = full[W-1:0];
  assign cy    = full[W] ^ sub;
  assign hc    = half[H] ^ sub;
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         cy
);
  always_comb begin
    res = '0;
    cy  = 1'b0;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_COM: res = ~a;
      OP_SHL: begin res = {a[W-2:0], 1'b0};   cy = a[W-1]; end
      OP_SHR: begin res = {1'b0, a[W-1:1]};   cy = a[0];   end
      OP_ROL: begin res = {a[W-2:0], a[W-1]}; cy = a[W-1]; end
      OP_ROR: begin res = {a[0], a[W-1:1]};   cy = a[0];   end
      default: res = '0;
    endcase
  end

  // R7
  always_comb begin
    if (op == OP_ROL || op == OP_ROR)
      rot_ones_chk: assert ($countones(res) == $countones(a));
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd,
  input  logic [3:0]   op,
  input  logic         flag_we,
  output logic [W-1:0] res_out,
  output logic [7:0]   flags_q
);
  alu_op_e      op_e;
  logic [W-1:0] as_a, as_b, as_sum, lg_res;
  logic         as_cin, as_sub, as_cy, as_hc, lg_cy;
  logic         arith_sel, logic_sel;
  logic         res_zero, res_sign, res_even;
  logic         next_cy, next_ac;
  logic [7:0]   flags_d;

  assign op_e      = alu_op_e'(op);
  assign arith_sel = uses_adder(op_e);
  assign logic_sel = is_logic_op(op_e);

  always_comb begin
    as_a   = acc_in;
    as_b   = opnd;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op_e)
      OP_ADC: as_cin = flags_q[FLG_CY];
      OP_SUB: as_sub = 1'b1;
      OP_SBB: begin as_sub = 1'b1; as_cin = flags_q[FLG_CY]; end
      OP_INC: as_b = W'(1);
      OP_DEC: begin as_b = W'(1); as_sub = 1'b1; end
      OP_NEG: begin as_a = '0; as_b = acc_in; as_sub = 1'b1; end
      default: ;
    endcase
  end

  acc_alu_addsub #(.W(W)) u_addsub (
    .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .cy(as_cy), .hc(as_hc)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .op(op_e), .a(acc_in), .b(opnd), .res(lg_res), .cy(lg_cy)
  );

  assign res_out  = arith_sel ? as_sum : lg_res;
  assign next_cy  = arith_sel ? as_cy : lg_cy;
  assign next_ac  = arith_sel & as_hc;
  assign res_zero = (res_out == '0);
  assign res_sign = res_out[W-1];
  assign res_even = ~(^res_out);

  always_comb begin
    flags_d         = 8'h00;
    flags_d[FLG_S]  = res_sign;
    flags_d[FLG_Z]  = res_zero;
    flags_d[FLG_AC] = next_ac;
    flags_d[FLG_P]  = res_even;
    flags_d[FLG_CY] = next_cy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= 8'h00;
    else if (flag_we) flags_q <= flags_d;
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags_q));
  // R8
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & FLG_SPARE_MASK) == 8'h00);
  // R3
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && res_out == '0) |=> flags_q[FLG_Z]);
  // R4
  sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags_q[FLG_S] == $past(res_out[W-1])));
  // R6
  logic_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && logic_sel) |=> (!flags_q[FLG_CY] && !flags_q[FLG_AC]));
endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] acc_in = 8'h00, opnd = 8'h00;
  logic [3:0] op = 4'd0;
  logic       flag_we = 1'b0;
  logic [7:0] res_out, flags_q;

  int checks = 0, errors = 0;
  logic [7:0] exp_flags = 8'h00;
  bit done = 0;

  always #2.5 clk = ~clk;

  acc_alu u0 (.clk(clk), .rst_n(rst_n), .acc_in(acc_in), .opnd(opnd),
              .op(op), .flag_we(flag_we), .res_out(res_out), .flags_q(flags_q));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural model: returns {flags, result}
  function automatic int model(int o, int a, int b, int cyin);
    int r = 0, c = 0, h = 0, t, ones = 0;
    case (o)
      0:  begin t = a + b;        c = t > 255; h = ((a%16)+(b%16)) > 15; r = t; end
      1:  begin t = a + b + cyin; c = t > 255; h = ((a%16)+(b%16)+cyin) > 15; r = t; end
      2:  begin t = a - b;        c = t < 0;   h = ((a%16)-(b%16)) < 0; r = t; end
      3:  begin t = a - b - cyin; c = t < 0;   h = ((a%16)-(b%16)-cyin) < 0; r = t; end
      4:  begin t = a + 1;        c = t > 255; h = ((a%16)+1) > 15; r = t; end
      5:  begin t = a - 1;        c = t < 0;   h = ((a%16)-1) < 0; r = t; end
      6:  begin t = 0 - a;        c = t < 0;   h = (0-(a%16)) < 0; r = t; end
      7:  r = a & b;
      8:  r = a | b;
      9:  r = a ^ b;
      10: r = 255 - a;
      11: r = 0;
      12: begin r = a * 2;               c = a / 128; end
      13: begin r = a / 2;               c = a % 2; end
      14: begin r = a * 2 + a / 128;     c = a / 128; end
      default: begin r = a / 2 + (a % 2) * 128; c = a % 2; end
    endcase
    r = r & 255;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    return (((r / 128) * 128 + (r == 0) * 64 + h * 16 + ((ones % 2) == 0) * 4 + c) << 8) | r;
  endfunction

  function automatic string tag_of(int o);
    if (o == 0 || o == 1 || o == 4) return "R1";
    if (o <= 6) return "R2";
    if (o <= 11) return "R6";
    return "R7";
  endfunction

  task automatic step(int o, int a, int b, bit we);
    int m, ef;
    @(negedge clk);
    op = 4'(o); acc_in = 8'(a); opnd = 8'(b); flag_we = we;
    #1;
    m = model(o, a, b, exp_flags[0]);
    check(tag_of(o), res_out, m & 255);
    ef = m >> 8;
    @(posedge clk); #1;
    if (we) begin
      exp_flags = 8'(ef);
      check("R3", flags_q[6], ef[6]);
      check("R4", {flags_q[7], flags_q[2]}, {ef[7], ef[2]});
      check("R5", flags_q[4], ef[4]);
      check(tag_of(o), flags_q[0], ef[0]);
      check("R8", flags_q, exp_flags);
    end else begin
      check("R9", flags_q, exp_flags);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R10", flags_q, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    // directed corners
    step(0, 8'hFF, 8'h01, 1);   // carry and zero
    step(1, 8'h0F, 8'h00, 1);   // ADC with CY=1, half carry
    step(2, 8'h10, 8'h01, 1);   // half borrow
    step(3, 8'h00, 8'h00, 1);   // SBB with CY=0
    step(2, 8'h00, 8'h01, 1);   // borrow
    step(3, 8'h05, 8'h05, 1);   // SBB with CY=1
    step(4, 8'hFF, 8'h33, 1);   // INC wraps, opnd ignored
    step(5, 8'h00, 8'h77, 1);   // DEC borrow
    step(6, 8'h00, 8'h12, 1);   // NEG of zero
    step(6, 8'h01, 8'h00, 1);
    step(10, 8'hA5, 8'h3C, 1);  // COM ignores opnd
    step(11, 8'hFF, 8'hFF, 1);  // CLR
    step(12, 8'h81, 8'h00, 1);
    step(13, 8'h01, 8'h00, 1);
    step(14, 8'h80, 8'h00, 1);
    step(15, 8'h01, 8'h00, 1);
    step(0, 8'h80, 8'h80, 0);   // no write: flags hold
    step(1, 8'h01, 8'h01, 1);   // ADC sees held CY
    // random mix, ~1 in 4 without write
    for (int k = 0; k < 600; k++)
      step(int'($urandom_range(15)), int'($urandom_range(255)),
           int'($urandom_range(255)), ($urandom_range(3) != 0));
    // reset mid-run clears flags
    step(0, 8'hFF, 8'hFF, 1);
    @(negedge clk); rst_n = 1'b0; #1;
    check("R10", flags_q, 8'h00);
    exp_flags = 8'h00;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule